// File: doc/BRIEF.md
# Indirect SDRAM Controller Register File

This block holds the configuration and status registers of an SDRAM controller. They are not mapped one by one onto the device control bus. The bus sees two locations instead. The first is a pointer that holds an internal offset. The second is a data window that reads or writes whichever internal register the pointer selects. Software loads the pointer and then reads or writes the window as many times as it needs.

Each register keeps only its own writable bits, and several writes have side effects. Turning the controller enable on or off, and entering or leaving self-refresh, is mirrored into a read-only status word. The two bus-error status words are sticky. The memory path sets their bits, and software clears a bit by writing 1 to it. The ECC error word drives an interrupt line that is high whenever the stored word is nonzero. The per-bank configuration words are exported together with the enable bit, so that an address decoder can tell which banks are live.

Top module: `sdram_cfg_regfile`

## Requirements
- R1: A bus write to address 0x10 loads the 32-bit pointer, and a bus read of 0x10 returns it. A bus read of any address other than 0x10 and 0x11 returns 0.
- R2: Read data is registered. It appears on `rd_data` one cycle after the cycle in which `rd_en` is high, and it holds its value while `rd_en` is low.
- R3: After reset, a read through the window returns 0x00800000 for config (offset 0x20), 0x05F00000 for the refresh timer (0x30) and 0x07C00000 for the power timer (0x34). Every other stored register reads 0. `ecc_irq` and `ctrl_en` are low.
- R4: The error status words at offsets 0x00 and 0x08 set a bit in the cycle after the matching `err_set0` or `err_set1` bit is high. A window write clears the bits that are written as 1 and leaves the others unchanged. If a set and a clear fall in the same cycle, the set wins.
- R5: A config write (offset 0x20) keeps bits 31:21 only. Config bit 31 is the enable and is driven out on `ctrl_en`. When the enable rises, status bit 31 clears. When it falls, status bit 31 sets.
- R6: When config bit 30 (self-refresh) rises, status bit 30 sets, and when it falls, status bit 30 clears. Writes to the status word (offset 0x24) have no effect.
- R7: The refresh timer (0x30) stores a write ANDed with 0x3FF80000. The power timer (0x34) stores bits 31:27 of a write, and bits 26:22 always read 1.
- R8: The bank words at offsets 0x40, 0x44, 0x48 and 0x4C store a write ANDed with 0xFFDEE001. Bank k is exported on `bank_cfg[32k+31:32k]`. `bank_live[k]` is high when bit 0 of bank word k is 1 and `ctrl_en` is high.
- R9: The ECC config word (0x94) stores a write ANDed with 0x00F00000. The error address word (0x10) stores every bit of a write.
- R10: The ECC error word (0x98) stores a write ANDed with 0xFFF0F000. `ecc_irq` is high in the cycle after a write that leaves the stored word nonzero, and low in the cycle after a write that leaves it zero.
- R11: A window read of the timing offset 0x80, or of any offset that holds no register, returns 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| bus_addr | input | 10 | Bus register address |
| wr_data | input | 32 | Bus write data |
| rd_data | output | 32 | Registered bus read data |
| err_set0 | input | 32 | Error bits to set in error status word 0 |
| err_set1 | input | 32 | Error bits to set in error status word 1 |
| ecc_irq | output | 1 | ECC error interrupt |
| ctrl_en | output | 1 | Controller enable |
| bank_cfg | output | 128 | Bank configuration words, bank 0 in the low bits |
| bank_live | output | 4 | Per-bank mapped indication |

## Verification
The assertions assume that a read strobe and a write strobe are never high in the same cycle. They also assume that the strobes are held low throughout reset. The bench issues every bus access through single-cycle tasks that raise exactly one strobe, and it does so only after reset has been released. The error-set inputs are pulsed only when no clear is in flight, except in the one case that checks set priority.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;
    localparam int unsigned DW = 32;

    localparam logic [DW-1:0] OFF_ERR0    = 32'h00;
    localparam logic [DW-1:0] OFF_ERR1    = 32'h08;
    localparam logic [DW-1:0] OFF_ERRADR  = 32'h10;
    localparam logic [DW-1:0] OFF_CFG     = 32'h20;
    localparam logic [DW-1:0] OFF_STAT    = 32'h24;
    localparam logic [DW-1:0] OFF_RFSH    = 32'h30;
    localparam logic [DW-1:0] OFF_PWR     = 32'h34;
    localparam logic [DW-1:0] OFF_BANK0   = 32'h40;
    localparam logic [DW-1:0] OFF_ECCCFG  = 32'h94;
    localparam logic [DW-1:0] OFF_ECCERR  = 32'h98;

    localparam logic [DW-1:0] MSK_CFG     = 32'hFFE0_0000;
    localparam logic [DW-1:0] MSK_RFSH    = 32'h3FF8_0000;
    localparam logic [DW-1:0] MSK_PWR     = 32'hF800_0000;
    localparam logic [DW-1:0] FORCE_PWR   = 32'h07C0_0000;
    localparam logic [DW-1:0] MSK_BANK    = 32'hFFDE_E001;
    localparam logic [DW-1:0] MSK_ECCCFG  = 32'h00F0_0000;
    localparam logic [DW-1:0] MSK_ECCERR  = 32'hFFF0_F000;

    localparam logic [DW-1:0] RST_CFG     = 32'h0080_0000;
    localparam logic [DW-1:0] RST_RFSH    = 32'h05F0_0000;
    localparam logic [DW-1:0] RST_PWR     = 32'h07C0_0000;
    localparam logic [DW-1:0] ALL_ONES    = '1;

    localparam int unsigned EN_BIT = 31;
    localparam int unsigned SR_BIT = 30;
endpackage

// File: rtl/sdram_cfg_ptr.sv
module sdram_cfg_ptr
    import sdram_cfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] ptr
);
    logic [DW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load) ptr_d = din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    // R1
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ptr == $past(din));
endmodule

// File: rtl/sdram_cfg_core.sv
module sdram_cfg_core
    import sdram_cfg_pkg::*;
#(
    parameter int unsigned NBANK = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                win_wr,
    input  logic [DW-1:0]       sel,
    input  logic [DW-1:0]       wdata,
    input  logic [DW-1:0]       set0,
    input  logic [DW-1:0]       set1,
    output logic [DW-1:0]       sel_val,
    output logic                irq,
    output logic                enable,
    output logic [NBANK*DW-1:0] banks,
    output logic [NBANK-1:0]    live
);
    typedef struct packed {
        logic [DW-1:0]            err0;
        logic [DW-1:0]            err1;
        logic [DW-1:0]            erradr;
        logic [DW-1:0]            cfg;
        logic [DW-1:0]            stat;
        logic [DW-1:0]            rfsh;
        logic [DW-1:0]            pwr;
        logic [NBANK-1:0][DW-1:0] bank;
        logic [DW-1:0]            ecccfg;
        logic [DW-1:0]            eccerr;
        logic                     irq;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [DW-1:0] cfg_v, ecc_v;

    always_comb begin
        st_d  = st_q;
        cfg_v = wdata & MSK_CFG;
        ecc_v = wdata & MSK_ECCERR;
        if (win_wr) begin
            case (sel)
                OFF_ERR0:   st_d.err0   = st_q.err0 & ~wdata;
                OFF_ERR1:   st_d.err1   = st_q.err1 & ~wdata;
                OFF_ERRADR: st_d.erradr = wdata;
                OFF_CFG: begin
                    if (!st_q.cfg[EN_BIT] && cfg_v[EN_BIT])      st_d.stat[EN_BIT] = 1'b0;
                    else if (st_q.cfg[EN_BIT] && !cfg_v[EN_BIT]) st_d.stat[EN_BIT] = 1'b1;
                    if (!st_q.cfg[SR_BIT] && cfg_v[SR_BIT])      st_d.stat[SR_BIT] = 1'b1;
                    else if (st_q.cfg[SR_BIT] && !cfg_v[SR_BIT]) st_d.stat[SR_BIT] = 1'b0;
                    st_d.cfg = cfg_v;
                end
                OFF_RFSH:   st_d.rfsh   = wdata & MSK_RFSH;
                OFF_PWR:    st_d.pwr    = (wdata & MSK_PWR) | FORCE_PWR;
                OFF_ECCCFG: st_d.ecccfg = wdata & MSK_ECCCFG;
                OFF_ECCERR: begin
                    st_d.eccerr = ecc_v;
                    st_d.irq    = (ecc_v != '0);
                end
                default: ;
            endcase
            for (int i = 0; i < NBANK; i++) begin
                if (sel == OFF_BANK0 + DW'(4 * i)) st_d.bank[i] = wdata & MSK_BANK;
            end
        end
        st_d.err0 = st_d.err0 | set0;
        st_d.err1 = st_d.err1 | set1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.cfg    <= RST_CFG;
            st_q.rfsh   <= RST_RFSH;
            st_q.pwr    <= RST_PWR;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        sel_val = ALL_ONES;
        case (sel)
            OFF_ERR0:   sel_val = st_q.err0;
            OFF_ERR1:   sel_val = st_q.err1;
            OFF_ERRADR: sel_val = st_q.erradr;
            OFF_CFG:    sel_val = st_q.cfg;
            OFF_STAT:   sel_val = st_q.stat;
            OFF_RFSH:   sel_val = st_q.rfsh;
            OFF_PWR:    sel_val = st_q.pwr;
            OFF_ECCCFG: sel_val = st_q.ecccfg;
            OFF_ECCERR: sel_val = st_q.eccerr;
            default: ;
        endcase
        for (int i = 0; i < NBANK; i++) begin
            if (sel == OFF_BANK0 + DW'(4 * i)) sel_val = st_q.bank[i];
        end
    end

    assign irq    = st_q.irq;
    assign enable = st_q.cfg[EN_BIT];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        assign banks[g*DW +: DW] = st_q.bank[g];
        assign live[g]           = st_q.bank[g][0] & st_q.cfg[EN_BIT];
    end

    // R5
    en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) |-> !st_q.stat[EN_BIT]);
    // R5
    en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(enable) |-> st_q.stat[EN_BIT]);
    // R6
    stat_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && sel == OFF_STAT) |=> $stable(st_q.stat));
    // R7
    pwr_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pwr & FORCE_PWR) == FORCE_PWR);
    // R10
    irq_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (st_q.eccerr != '0));
    // R4
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set0 != '0) |=> ((st_q.err0 & $past(set0)) == $past(set0)));
endmodule

// File: rtl/sdram_cfg_rdmux.sv
module sdram_cfg_rdmux
    import sdram_cfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  logic          is_ptr,
    input  logic          is_win,
    input  logic [DW-1:0] ptr,
    input  logic [DW-1:0] win_val,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (rd) begin
            if (is_ptr)      rd_d = ptr;
            else if (is_win) rd_d = win_val;
            else             rd_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata = rd_q;

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));
    // R1
    rd_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !is_ptr && !is_win) |=> rdata == '0);
endmodule

// File: rtl/sdram_cfg_regfile.sv
module sdram_cfg_regfile
    import sdram_cfg_pkg::*;
#(
    parameter int unsigned AW       = 10,
    parameter int unsigned NBANK    = 4,
    parameter logic [AW-1:0] PTR_ADDR = 10'h010
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DW-1:0]       wr_data,
    output logic [DW-1:0]       rd_data,
    input  logic [DW-1:0]       err_set0,
    input  logic [DW-1:0]       err_set1,
    output logic                ecc_irq,
    output logic                ctrl_en,
    output logic [NBANK*DW-1:0] bank_cfg,
    output logic [NBANK-1:0]    bank_live
);
    localparam logic [AW-1:0] WIN_ADDR = PTR_ADDR + AW'(1);

    logic          hit_ptr, hit_win;
    logic [DW-1:0] ptr, win_val;

    assign hit_ptr = (bus_addr == PTR_ADDR);
    assign hit_win = (bus_addr == WIN_ADDR);

    sdram_cfg_ptr u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_en & hit_ptr),
        .din   (wr_data),
        .ptr   (ptr)
    );

    sdram_cfg_core #(.NBANK(NBANK)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_wr  (wr_en & hit_win),
        .sel     (ptr),
        .wdata   (wr_data),
        .set0    (err_set0),
        .set1    (err_set1),
        .sel_val (win_val),
        .irq     (ecc_irq),
        .enable  (ctrl_en),
        .banks   (bank_cfg),
        .live    (bank_live)
    );

    sdram_cfg_rdmux u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (rd_en),
        .is_ptr  (hit_ptr),
        .is_win  (hit_win),
        .ptr     (ptr),
        .win_val (win_val),
        .rdata   (rd_data)
    );

    // R2
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));
endmodule

// File: tb/sdram_cfg_regfile_test.sv
module sdram_cfg_regfile_test;
    logic         clk = 0;
    logic         rst_n = 0;
    logic         wr_en = 0, rd_en = 0;
    logic [9:0]   bus_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [31:0]  rd_data;
    logic [31:0]  err_set0 = '0, err_set1 = '0;
    logic         ecc_irq, ctrl_en;
    logic [127:0] bank_cfg;
    logic [3:0]   bank_live;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sdram_cfg_regfile uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .bus_addr(bus_addr), .wr_data(wr_data), .rd_data(rd_data),
        .err_set0(err_set0), .err_set1(err_set1), .ecc_irq(ecc_irq),
        .ctrl_en(ctrl_en), .bank_cfg(bank_cfg), .bank_live(bank_live)
    );

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [9:0] a, logic [31:0] d);
        @(negedge clk); wr_en = 1; bus_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic bus_rd(logic [9:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1; bus_addr = a;
        @(negedge clk); rd_en = 0; d = rd_data;
    endtask

    task automatic wwr(logic [31:0] off, logic [31:0] d);
        bus_wr(10'h010, off); bus_wr(10'h011, d);
    endtask

    task automatic wrd(logic [31:0] off, output logic [31:0] d);
        bus_wr(10'h010, off); bus_rd(10'h011, d);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R3 irq", ecc_irq, 0); chk("R3 en", ctrl_en, 0);
        wrd(32'h20, v); chk("R3 cfg", v, 32'h0080_0000);
        wrd(32'h30, v); chk("R3 rfsh", v, 32'h05F0_0000);
        wrd(32'h34, v); chk("R3 pwr", v, 32'h07C0_0000);
        wrd(32'h24, v); chk("R3 stat", v, 0);
        wrd(32'h98, v); chk("R3 eccerr", v, 0);
        wrd(32'h4C, v); chk("R3 bank3", v, 0);
    endtask

    task automatic t_ptr;
        logic [31:0] v;
        bus_wr(10'h010, 32'hA5A5_0123);
        bus_rd(10'h010, v); chk("R1 ptr", v, 32'hA5A5_0123);
        bus_rd(10'h012, v); chk("R1 other", v, 0);
        bus_rd(10'h010, v);
        repeat (3) @(negedge clk);
        chk("R2 hold", rd_data, 32'hA5A5_0123);
        @(negedge clk); rd_en = 1; bus_addr = 10'h012;
        chk("R2 no early", rd_data, 32'hA5A5_0123);
        @(negedge clk); rd_en = 0;
        chk("R2 one cycle", rd_data, 0);
    endtask

    task automatic t_err;
        logic [31:0] v;
        @(negedge clk); err_set0 = 32'hF0F0_00FF; err_set1 = 32'h0000_0003;
        @(negedge clk); err_set0 = 0; err_set1 = 0;
        wrd(32'h00, v); chk("R4 set0", v, 32'hF0F0_00FF);
        wwr(32'h00, 32'h0000_000F);
        wrd(32'h00, v); chk("R4 w1c", v, 32'hF0F0_00F0);
        bus_wr(10'h010, 32'h08);
        @(negedge clk); wr_en = 1; bus_addr = 10'h011; wr_data = 32'h3; err_set1 = 32'h1;
        @(negedge clk); wr_en = 0; err_set1 = 0;
        wrd(32'h08, v); chk("R4 set wins", v, 32'h1);
    endtask

    task automatic t_cfg;
        logic [31:0] v;
        wwr(32'h20, 32'h801F_FFFF);
        chk("R5 en", ctrl_en, 1);
        wrd(32'h20, v); chk("R5 mask", v, 32'h8000_0000);
        wwr(32'h20, 32'h0);
        chk("R5 off", ctrl_en, 0);
        wrd(32'h24, v); chk("R5 stat fall", v, 32'h8000_0000);
        wwr(32'h20, 32'hC000_0000);
        wrd(32'h24, v); chk("R6 sr rise", v, 32'h4000_0000);
        wwr(32'h24, 32'h0);
        wrd(32'h24, v); chk("R6 stat ro", v, 32'h4000_0000);
        wwr(32'h20, 32'h0);
        wrd(32'h24, v); chk("R6 sr fall", v, 32'h8000_0000);
    endtask

    task automatic t_timers;
        logic [31:0] v;
        wwr(32'h30, 32'hFFFF_FFFF);
        wrd(32'h30, v); chk("R7 rfsh", v, 32'h3FF8_0000);
        wwr(32'h34, 32'h0);
        wrd(32'h34, v); chk("R7 pwr zero", v, 32'h07C0_0000);
        wwr(32'h34, 32'hFFFF_FFFF);
        wrd(32'h34, v); chk("R7 pwr ones", v, 32'hFFC0_0000);
        wwr(32'h94, 32'hFFFF_FFFF);
        wrd(32'h94, v); chk("R9 ecccfg", v, 32'h00F0_0000);
        wwr(32'h10, 32'h1234_5678);
        wrd(32'h10, v); chk("R9 erradr", v, 32'h1234_5678);
    endtask

    task automatic t_bank;
        logic [31:0] v;
        wwr(32'h44, 32'hFFFF_FFFF);
        wrd(32'h44, v); chk("R8 bank1", v, 32'hFFDE_E001);
        chk("R8 port", bank_cfg, {64'h0, 32'hFFDE_E001, 32'h0});
        chk("R8 live off", bank_live, 4'b0000);
        wwr(32'h20, 32'h8000_0000);
        chk("R8 live on", bank_live, 4'b0010);
        wwr(32'h4C, 32'h0080_0001);
        chk("R8 bank3", bank_cfg[127:96], 32'h0080_0001);
        chk("R8 live two", bank_live, 4'b1010);
        wwr(32'h20, 32'h0);
        chk("R8 live off2", bank_live, 4'b0000);
    endtask

    task automatic t_ecc;
        logic [31:0] v;
        wwr(32'h98, 32'h000F_0FFF);
        chk("R10 masked zero", ecc_irq, 0);
        wwr(32'h98, 32'h1234_5678);
        chk("R10 raise", ecc_irq, 1);
        wrd(32'h98, v); chk("R10 mask", v, 32'h1230_5000);
        wwr(32'h98, 32'h0);
        chk("R10 lower", ecc_irq, 0);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        wwr(32'h80, 32'h0);
        wrd(32'h80, v); chk("R11 timing", v, 32'hFFFF_FFFF);
        wrd(32'h04, v); chk("R11 hole", v, 32'hFFFF_FFFF);
        wrd(32'h200, v); chk("R11 far", v, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_ptr();
        t_err();
        t_cfg();
        t_timers();
        t_bank();
        t_ecc();
        t_unmapped();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule